// File: doc/BRIEF.md
# Power-down entry/exit sequencer

This block steps a device into and out of its low-power state. Its input is an active-low power-down request. After reset the request is treated as released, as if a pull-up held it high. The request first passes through a two-flop synchroniser. A pulse-width filter then accepts it only once it has stayed low for a minimum time. Shorter glitches never reach the sequencer.

On entry the block does three things in order:
- it cuts the input buffers, forcing every gated input to logic low;
- it asserts global set/reset in the same cycle;
- it disables the outputs one 10 ns interval later.

On exit the order is staggered the other way:
- the inputs come back first;
- global set/reset is released on the next cycle;
- the outputs return one 10 ns interval after that;
- ready rises once 50 ns have passed since the inputs came back.

An entry that has started always completes before any exit begins.

All timing comes from the parameter `CYC_PER_10NS`, the number of clock cycles in 10 ns, which is clamped to at least 1. Below, C stands for that clamped value. The 50 ns windows are 5*C cycles and the 10 ns steps are C cycles. Latencies are counted in clock edges from the cycle in which the request pin changes.

Top module: `pd_sequencer`

## Requirements
- R1: After reset the outputs are `input_en`=1, `gsr`=0, `output_en`=1, `ready`=1, and `in_gated` equals `in_raw`.
- R2: A low pulse on `pd_req_n` lasting fewer than 5*C cycles is ignored, and all outputs stay in their active values. A low pulse of exactly 5*C cycles is accepted.
- R3: For an accepted request, `input_en` falls and `gsr` rises in the same cycle, 5*C+3 cycles after `pd_req_n` goes low.
- R4: `output_en` falls exactly C cycles after `input_en` falls.
- R5: While `input_en` is 0, every bit of `in_gated` is 0. While `input_en` is 1, `in_gated` equals `in_raw`.
- R6: On release, `input_en` rises 4 cycles after `pd_req_n` goes high. If power-down has not yet been reached at that point, it rises one cycle after power-down is reached instead. `gsr` falls exactly one cycle after `input_en` rises.
- R7: `output_en` rises exactly C cycles after `gsr` falls.
- R8: `ready` rises exactly 5*C cycles after `input_en` rises. `ready` is 0 whenever any of `input_en`=0, `output_en`=0 or `gsr`=1 holds.
- R9: If the request is released while the entry is still in progress, `output_en` still falls (the entry completes) before the exit sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| in_raw | input | N_IN | Pad inputs subject to gating |
| in_gated | output | N_IN | Pad inputs after gating, forced low while powered down |
| input_en | output | 1 | Input buffer enable |
| gsr | output | 1 | Global set/reset |
| output_en | output | 1 | Output buffer enable |
| ready | output | 1 | Device usable, fully active |

## Verification
A corrupted filter count shows up as a power-down latency that is off by some cycles, or as a short glitch being accepted. Either is visible at `input_en` within 5*C+3 cycles of the request edge. A sequencer stuck in or skipping a state breaks the fixed spacing between the falls and rises of `input_en`, `gsr`, `output_en` and `ready`. That spacing is checked to the exact cycle, so a wrong state appears within C cycles of the misstep. Leakage of a pad input through the gate appears directly on `in_gated` during the power-down window.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_ENTER,
        ST_DOWN,
        ST_WAKE,
        ST_RELEASE,
        ST_SETTLE
    } pd_state_e;
endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = async_n;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1};
        else        r_q <= r_d;
    end

    assign sync_n = r_q.s2;
endmodule

// File: rtl/pdseq_filter.sv
module pdseq_filter #(
    parameter int HOLD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_low,
    output logic accepted
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          acc;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!req_low) begin
            f_d.cnt = '0;
            f_d.acc = 1'b0;
        end else if (!f_q.acc) begin
            if (f_q.cnt == CW'(HOLD - 1)) f_d.acc = 1'b1;
            else                          f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign accepted = f_q.acc;
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int STEP   = 2,
    parameter int SETTLE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic input_en,
    output logic gsr,
    output logic output_en,
    output logic ready
);
    localparam int CW = $clog2(SETTLE + 1);

    typedef struct packed {
        pd_state_e     st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_ACTIVE: if (pd) begin
                s_d.st  = ST_ENTER;
                s_d.cnt = '0;
            end
            ST_ENTER: begin
                if (s_q.cnt == CW'(STEP - 1)) s_d.st = ST_DOWN;
                else                          s_d.cnt = s_q.cnt + 1'b1;
            end
            ST_DOWN: if (!pd) begin
                s_d.st  = ST_WAKE;
                s_d.cnt = '0;
            end
            ST_WAKE: begin
                s_d.st  = ST_RELEASE;
                s_d.cnt = s_q.cnt + 1'b1;
            end
            ST_RELEASE: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CW'(STEP)) s_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CW'(SETTLE - 1)) s_d.st = ST_ACTIVE;
            end
            default: begin
                s_d.st  = ST_ACTIVE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_ACTIVE, cnt: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        input_en  = 1'b1;
        gsr       = 1'b0;
        output_en = 1'b1;
        ready     = 1'b0;
        case (s_q.st)
            ST_ACTIVE:  ready = 1'b1;
            ST_ENTER:   begin input_en = 1'b0; gsr = 1'b1; end
            ST_DOWN:    begin input_en = 1'b0; gsr = 1'b1; output_en = 1'b0; end
            ST_WAKE:    begin gsr = 1'b1; output_en = 1'b0; end
            ST_RELEASE: output_en = 1'b0;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
    parameter int CYC_PER_10NS = 2,
    parameter int N_IN         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_req_n,
    input  logic [N_IN-1:0] in_raw,
    output logic [N_IN-1:0] in_gated,
    output logic            input_en,
    output logic            gsr,
    output logic            output_en,
    output logic            ready
);
    localparam int C   = (CYC_PER_10NS < 1) ? 1 : CYC_PER_10NS;
    localparam int T50 = 5 * C;

    logic req_sync_n;
    logic pd_accepted;

    pdseq_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (pd_req_n),
        .sync_n  (req_sync_n)
    );

    pdseq_filter #(.HOLD(T50)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_low  (!req_sync_n),
        .accepted (pd_accepted)
    );

    pdseq_fsm #(.STEP(C), .SETTLE(T50)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd        (pd_accepted),
        .input_en  (input_en),
        .gsr       (gsr),
        .output_en (output_en),
        .ready     (ready)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_gate
        assign in_gated[i] = in_raw[i] & input_en;
    end
endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker #(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] in_raw,
    input logic [N_IN-1:0] in_gated,
    input logic            input_en,
    input logic            gsr,
    input logic            output_en,
    input logic            ready
);
    assert_entry_gsr_with_inputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(input_en) |-> ($rose(gsr) && output_en));

    assert_outputs_after_inputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(output_en) |-> ($past(!input_en) && gsr));

    assert_gated_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !input_en |-> (in_gated == '0));

    assert_gated_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        input_en |-> (in_gated == in_raw));

    assert_gsr_after_inputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gsr) |-> ($past(input_en) && !output_en));

    assert_outputs_back_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(output_en) |-> (!gsr && input_en));

    assert_ready_only_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (input_en && output_en && !gsr));
endmodule

bind pd_sequencer pdseq_checker #(.N_IN(N_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_raw    (in_raw),
    .in_gated  (in_gated),
    .input_en  (input_en),
    .gsr       (gsr),
    .output_en (output_en),
    .ready     (ready)
);

// File: tb/tb_pd_sequencer.sv
module tb_pd_sequencer;
    localparam int C    = 2;
    localparam int T50  = 5 * C;
    localparam int N_IN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req_n = 1'b1;
    logic [N_IN-1:0] in_raw = '0;
    logic [N_IN-1:0] in_gated;
    logic input_en, gsr, output_en, ready;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pd_sequencer #(.CYC_PER_10NS(C), .N_IN(N_IN)) dut (
        .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .in_raw(in_raw),
        .in_gated(in_gated), .input_en(input_en), .gsr(gsr),
        .output_en(output_en), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_wake(input int len);
        int a, b;
        a = len + 4;
        b = T50 + 3 + C + 1;
        return (a > b) ? a : b;
    endfunction

    task automatic run_pulse(input int len);
        int t0, rel;
        int t_ief, t_oef, t_gsrr, t_ier, t_gsrf, t_oer, t_rdy;
        bit gate_ok, rdy_ok, idle_ok;
        int span;
        t_ief = -1; t_oef = -1; t_gsrr = -1; t_ier = -1;
        t_gsrf = -1; t_oer = -1; t_rdy = -1;
        gate_ok = 1'b1; rdy_ok = 1'b1; idle_ok = 1'b1;
        span = len + 3 * T50 + C + 12;
        @(posedge clk); #2;
        pd_req_n = 1'b0;
        t0 = cyc;
        for (int i = 0; i < span; i++) begin
            @(posedge clk); #2;
            rel = cyc - t0;
            if (rel == len) pd_req_n = 1'b1;
            in_raw = N_IN'($urandom);
            @(negedge clk);
            if (!input_en && in_gated != '0) gate_ok = 1'b0;
            if (input_en && in_gated != in_raw) gate_ok = 1'b0;
            if (ready && (!input_en || !output_en || gsr)) rdy_ok = 1'b0;
            if (!input_en || gsr || !output_en || !ready) idle_ok = 1'b0;
            if (t_ief < 0 && !input_en) t_ief = rel;
            if (t_gsrr < 0 && gsr) t_gsrr = rel;
            if (t_oef < 0 && !output_en) t_oef = rel;
            if (t_ief >= 0 && t_ier < 0 && input_en) t_ier = rel;
            if (t_gsrr >= 0 && t_gsrf < 0 && !gsr) t_gsrf = rel;
            if (t_oef >= 0 && t_oer < 0 && output_en) t_oer = rel;
            if (t_ier >= 0 && t_rdy < 0 && ready) t_rdy = rel;
        end
        chk(gate_ok, "R5 gating", int'(gate_ok), 1);
        if (len < T50) begin
            chk(idle_ok, "R2 short pulse ignored", int'(idle_ok), 1);
        end else begin
            chk(t_ief == T50 + 3, "R3 input_en fall", t_ief, T50 + 3);
            chk(t_gsrr == t_ief, "R3 gsr rise", t_gsrr, t_ief);
            chk(t_oef == T50 + 3 + C, "R4 output_en fall", t_oef, T50 + 3 + C);
            chk(t_ier == exp_wake(len), "R6 input_en rise", t_ier, exp_wake(len));
            chk(t_gsrf == t_ier + 1, "R6 gsr fall", t_gsrf, t_ier + 1);
            chk(t_oer == t_gsrf + C, "R7 output_en rise", t_oer, t_gsrf + C);
            chk(t_rdy == t_ier + T50, "R8 ready rise", t_rdy, t_ier + T50);
            chk(rdy_ok, "R8 ready only when active", int'(rdy_ok), 1);
            if (len < T50 + 3 + C)
                chk(t_oef >= 0 && t_oef < t_ier, "R9 entry completes", t_oef, T50 + 3 + C);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        in_raw = 8'hA5;
        @(negedge clk);
        chk(input_en && !gsr && output_en && ready, "R1 reset outputs",
            {input_en, gsr, output_en, ready}, 4'b1011);
        chk(in_gated == in_raw, "R1 gated passthrough", in_gated, in_raw);
        run_pulse(T50 - 1);
        run_pulse(T50);
        run_pulse(1);
        run_pulse(T50 + 1);
        run_pulse(T50 + 3 + C);
        run_pulse(T50 * 3);
        for (int k = 0; k < 30; k++)
            run_pulse(1 + int'($urandom_range(2 * T50 + 4)));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule